// File: doc/BRIEF.md
# Two-Bank Burst Prefetch Memory Model

This block is a cycle-accurate, synthesizable model of a small DRAM-like memory. Its storage core is slow: one core access takes `CORE_LAT` interface cycles. Each access reads a whole row slice of `N` columns at once into a per-bank prefetch buffer. The buffer is then shifted out over a narrow `W`-bit data port, one column per interface cycle, for `N` back-to-back beats. Every access returns a full burst. The requester gives a start column and a useful length. Beats outside that length are still driven, but they are marked as not useful, so a user can measure wasted bandwidth.

The model has two independent banks. Each bank has its own row storage, core-access timer, prefetch buffer and beat selector. A core access in one bank can run while the other bank is streaming its burst. Bursts leave the block in the order their requests were accepted. When the next burst's data is already buffered, it follows the previous last beat with no idle cycle.

Requests use a valid/ready handshake. Back-pressure works like this: `req_ready` reflects only whether the addressed bank can take a request. A requester that sees `req_ready` low must hold `req_valid` and the whole payload unchanged until a rising edge on which both are high. That edge is the acceptance edge. The read port has no back-pressure, because a memory data bus cannot be stalled. Its beats are qualified by `rd_valid`.

Top module: `burst_mem`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `rd_valid` is 0 and `req_ready` is 1 for either bank.
- R2: If a request is accepted at rising edge k and no earlier burst is still pending, its first beat is presented in the cycle that follows edge k+CORE_LAT.
- R3: Each accepted request produces exactly `N` beats on consecutive cycles. `rd_bank` stays equal to the requested bank throughout, and `rd_last` is high on the N-th beat only.
- R4: Beat j (counting from 0) of a request carries the cell at column (col+j) mod N of the requested bank and row. The cell at bank b, row r, column c holds the low W bits of SEED + i + (i>>W) + (i>>2W), where i = (b·ROWS + r)·N + c.
- R5: `rd_useful` is 1 on beat j exactly when j < `req_len`. A length of 0 marks every beat as discarded, and a length of N or more marks every beat as useful.
- R6: While one bank is in its core access, a request to the other bank is accepted on the very next cycle, so the two core accesses overlap.
- R7: Bursts are returned in acceptance order. A burst whose core access has finished starts in the cycle right after the previous burst's last beat, leaving no idle cycle.
- R8: A bank on its final beat accepts its next request in that same cycle. When it works alone, the port is idle for exactly CORE_LAT cycles between the two bursts.
- R9: `req_ready` is low when the addressed bank is in a core access, is holding a buffered burst, or is streaming any beat other than its last. It is therefore low whenever both banks are busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; reloads the cell pattern |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Addressed bank can accept a request this cycle |
| req_bank | input | BANK_W (1) | Bank selected by the request |
| req_row | input | ROW_W (3) | Row selected inside the bank |
| req_col | input | COL_W (2) | First column of the burst |
| req_len | input | LEN_W (3) | Number of leading beats the requester will use |
| rd_valid | output | 1 | A burst beat is on `rd_data` |
| rd_data | output | W (2) | Beat data |
| rd_useful | output | 1 | Beat lies inside the requested length |
| rd_last | output | 1 | Final beat of the burst |
| rd_bank | output | BANK_W (1) | Bank that is sending the beat |

## Verification
Each beat is due on a known rising edge. For a request accepted at edge k, the first beat follows edge max(k+CORE_LAT, end of the previous burst), and the later beats follow on the next N−1 edges. The driver notes the edge number of acceptance and computes that target edge for every beat it queues. The monitor samples on falling edges and compares the current edge count with the due edge of the oldest expected beat. A beat that comes early, late or out of order is therefore reported as a timing failure, in addition to any data, flag or bank mismatch. `req_ready` and the acceptance edge of a same-bank follow-up request are checked one cycle after the stimulus that blocks or releases them.

// File: rtl/burst_mem_pkg.sv
package burst_mem_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,  // nothing pending in this bank
    S_CORE = 2'd1,  // core access in flight
    S_FULL = 2'd2,  // prefetch buffer loaded, waiting for the port
    S_XFER = 2'd3   // streaming beats
  } bank_state_e;

  // Reset-time content of one cell: a digit-sum mix of its linear index.
  function automatic int cell_value(int seed, int bank, int row, int col,
                                    int rows, int n, int w);
    int idx;
    idx = (bank * rows + row) * n + col;
    return (seed + idx + (idx >> w) + (idx >> (2 * w))) & ((1 << w) - 1);
  endfunction

endpackage

// File: rtl/burst_mem_order_fifo.sv
module burst_mem_order_fifo #(
  parameter int DEPTH = 2,
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slots_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full;

  function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) slots_q[i] <= '0;
    end else begin
      if (push) begin
        slots_q[wr_q] <= din;
        wr_q          <= step(wr_q);
      end
      if (pop) rd_q <= step(rd_q);
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head  = slots_q[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));

  // R7: order bookkeeping never loses or invents an entry
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/burst_mem_core.sv
module burst_mem_core
  import burst_mem_pkg::*;
#(
  parameter int ROWS     = 8,
  parameter int N        = 4,
  parameter int W        = 2,
  parameter int CORE_LAT = 8,
  parameter int BANK_ID  = 0,
  parameter int SEED     = 5,
  localparam int ROW_W   = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ROW_W-1:0] row,
  output logic             done,
  output logic [N*W-1:0]   slice
);
  localparam int LAT_W = $clog2(CORE_LAT + 1);

  logic [N*W-1:0]   cells_q [ROWS];
  logic             busy_q;
  logic [LAT_W-1:0] cnt_q;
  logic [ROW_W-1:0] row_q;

  // Core array: loaded with the reset pattern, one row slice = N cells.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < N; c++)
          cells_q[r][c*W +: W] <= W'(cell_value(SEED, BANK_ID, r, c, ROWS, N, W));
    end
  end

  // Access timer: done rises CORE_LAT edges after start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      row_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= LAT_W'(CORE_LAT - 1);
      row_q  <= row;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done  = busy_q && (cnt_q == '0);
  assign slice = cells_q[row_q];

  // R2: a new access never lands on one in flight, and each ends after done
  p_start_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
  p_done_retires_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);

endmodule

// File: rtl/burst_mem_serializer.sv
module burst_mem_serializer
  import burst_mem_pkg::*;
#(
  parameter int N      = 4,
  parameter int W      = 2,
  localparam int COL_W = $clog2(N),
  localparam int LEN_W = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [COL_W-1:0] col,
  input  logic [LEN_W-1:0] len,
  input  logic             core_done,
  input  logic [N*W-1:0]   slice,
  input  logic             go,
  output logic             can_accept,
  output logic             want,
  output logic             active,
  output logic             last,
  output logic [W-1:0]     beat_data,
  output logic             beat_useful
);
  bank_state_e      state_q;
  logic [COL_W-1:0] beat_q, col_q, col_idx;
  logic [LEN_W-1:0] len_q;
  logic [N*W-1:0]   buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      beat_q  <= '0;
      col_q   <= '0;
      len_q   <= '0;
      buf_q   <= '0;
    end else begin
      if (accept) begin
        col_q <= col;
        len_q <= len;
      end
      case (state_q)
        S_IDLE: if (accept) state_q <= S_CORE;
        S_CORE: if (core_done) begin
          buf_q   <= slice;
          state_q <= go ? S_XFER : S_FULL;
        end
        S_FULL: if (go) state_q <= S_XFER;
        S_XFER: begin
          beat_q <= beat_q + 1'b1;  // power-of-two N: wraps to 0 after last
          if (last) state_q <= accept ? S_CORE : S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign active      = (state_q == S_XFER);
  assign last        = active && (beat_q == COL_W'(N - 1));
  assign want        = (state_q == S_FULL) || ((state_q == S_CORE) && core_done);
  assign can_accept  = (state_q == S_IDLE) || last;
  assign col_idx     = col_q + beat_q;
  assign beat_data   = buf_q[col_idx*W +: W];
  assign beat_useful = active && (LEN_W'(beat_q) < len_q);

  // R3: once a burst starts it runs without a gap until its last beat
  p_burst_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active && !last |=> active);
  // R5: a discarded beat is never followed by a useful one in the same burst
  p_discard_sticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active && !last && !beat_useful |=> !beat_useful);
  // R7: the port is granted only to a bank whose data is buffered
  p_grant_has_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> want);

endmodule

// File: rtl/burst_mem.sv
module burst_mem
  import burst_mem_pkg::*;
#(
  parameter int N         = 4,
  parameter int W         = 2,
  parameter int ROWS      = 8,
  parameter int BANKS     = 2,
  parameter int CORE_LAT  = 2 * N,
  parameter int SEED      = 5,
  localparam int BANK_W   = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int ROW_W    = $clog2(ROWS),
  localparam int COL_W    = $clog2(N),
  localparam int LEN_W    = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [LEN_W-1:0]  req_len,
  output logic              rd_valid,
  output logic [W-1:0]      rd_data,
  output logic              rd_useful,
  output logic              rd_last,
  output logic [BANK_W-1:0] rd_bank
);
  logic [BANKS-1:0]  accept_vec, can_accept_vec, want_vec, active_vec, last_vec, go_vec;
  logic [BANKS-1:0]  useful_vec, done_vec;
  logic [W-1:0]      beat_arr [BANKS];
  logic [BANK_W-1:0] head;
  logic              fifo_empty, out_free, push, pop;

  assign req_ready = can_accept_vec[req_bank];
  assign push      = req_valid && req_ready;
  assign pop       = |go_vec;
  assign out_free  = !(|active_vec) || (|(active_vec & last_vec));

  burst_mem_order_fifo #(.DEPTH(BANKS), .WIDTH(BANK_W)) u_order (
    .clk(clk), .rst_n(rst_n), .push(push), .din(req_bank),
    .pop(pop), .head(head), .empty(fifo_empty)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [N*W-1:0] slice;

    assign accept_vec[b] = push && (req_bank == BANK_W'(b));
    assign go_vec[b]     = !fifo_empty && (head == BANK_W'(b)) && out_free && want_vec[b];

    burst_mem_core #(
      .ROWS(ROWS), .N(N), .W(W), .CORE_LAT(CORE_LAT), .BANK_ID(b), .SEED(SEED)
    ) u_core (
      .clk(clk), .rst_n(rst_n), .start(accept_vec[b]), .row(req_row),
      .done(done_vec[b]), .slice(slice)
    );

    burst_mem_serializer #(.N(N), .W(W)) u_ser (
      .clk(clk), .rst_n(rst_n), .accept(accept_vec[b]), .col(req_col), .len(req_len),
      .core_done(done_vec[b]), .slice(slice), .go(go_vec[b]),
      .can_accept(can_accept_vec[b]), .want(want_vec[b]), .active(active_vec[b]),
      .last(last_vec[b]), .beat_data(beat_arr[b]), .beat_useful(useful_vec[b])
    );
  end

  always_comb begin
    rd_valid  = 1'b0;
    rd_data   = '0;
    rd_useful = 1'b0;
    rd_last   = 1'b0;
    rd_bank   = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (active_vec[b]) begin
        rd_valid  = 1'b1;
        rd_data   = beat_arr[b];
        rd_useful = useful_vec[b];
        rd_last   = last_vec[b];
        rd_bank   = BANK_W'(b);
      end
    end
  end

  // R3: only one bank drives the port at a time
  p_one_driver_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(active_vec));
  // R3: a burst keeps its bank and continues until rd_last
  p_bank_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_last |=> rd_valid && (rd_bank == $past(rd_bank)));
  // R7: buffered data for the next burst follows the last beat directly
  p_gapless_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_last && !fifo_empty && want_vec[head] |=> rd_valid);
  // R9: no bank free means no acceptance
  p_ready_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (can_accept_vec == '0) |-> !req_ready);

endmodule

// File: tb/tb_burst_mem.sv
module tb_burst_mem;
  localparam int N = 4, W = 2, ROWS = 8, BANKS = 2, LAT = 8, SEED = 5;
  localparam int BANK_W = 1, ROW_W = 3, COL_W = 2, LEN_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic              req_valid = 1'b0, req_ready;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic              rd_valid, rd_useful, rd_last;
  logic [W-1:0]      rd_data;
  logic [BANK_W-1:0] rd_bank;

  burst_mem #(.N(N), .W(W), .ROWS(ROWS), .BANKS(BANKS), .CORE_LAT(LAT), .SEED(SEED)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_len(req_len),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_useful(rd_useful),
    .rd_last(rd_last), .rd_bank(rd_bank)
  );

  typedef struct { int due; int bank; int data; bit useful; bit last; int tag; } beat_t;
  beat_t exp_q[$];
  int checks = 0, errors = 0, edge_n = 0, next_free = 0;
  bit finished = 1'b0;

  always @(posedge clk) edge_n <= edge_n + 1;

  function automatic int exp_cell(int b, int r, int c);
    int i;
    i = (b * ROWS + r) * N + c;
    return (SEED + i + (i >> W) + (i >> (2 * W))) & ((1 << W) - 1);
  endfunction

  function automatic string tag_name(int t);
    case (t)
      6:       return "R6";
      7:       return "R7";
      8:       return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic check_eq(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Driver: holds the request until ready, then queues the N expected beats.
  task automatic send(input int b, input int r, input int c, input int l, input int tag,
                      output int acc, output int first);
    @(negedge clk);
    req_valid = 1'b1;
    req_bank  = BANK_W'(b);
    req_row   = ROW_W'(r);
    req_col   = COL_W'(c);
    req_len   = LEN_W'(l);
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    acc   = edge_n + 1;
    first = (acc + LAT > next_free) ? acc + LAT : next_free;
    for (int k = 0; k < N; k++) begin
      beat_t e;
      e.due = first + k;
      e.bank = b;
      e.data = exp_cell(b, r, (c + k) % N);
      e.useful = (k < l);
      e.last = (k == N - 1);
      e.tag = tag;
      exp_q.push_back(e);
    end
    next_free = first + N;
    @(posedge clk);
  endtask

  task automatic idle_req;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain;
    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: compares each beat with the oldest expected one, edge included.
  always @(negedge clk) begin
    beat_t e;
    if (rst_n && !finished) begin
      if (rd_valid) begin
        if (exp_q.size() == 0) check_eq("R3", "unexpected beat", 1, 0);
        else begin
          e = exp_q.pop_front();
          check_eq(tag_name(e.tag), "beat edge", edge_n, e.due);
          check_eq("R4", "beat data", int'(rd_data), e.data);
          check_eq("R5", "useful flag", int'(rd_useful), int'(e.useful));
          check_eq("R3", "last flag", int'(rd_last), int'(e.last));
          check_eq("R3", "beat bank", int'(rd_bank), e.bank);
        end
      end else if (exp_q.size() > 0 && exp_q[0].due <= edge_n) begin
        e = exp_q.pop_front();
        check_eq(tag_name(e.tag), "beat missing on its edge", 0, 1);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (edge_n > 20000 && !finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d edges expected fewer than 20000", edge_n);
      summary();
      $finish;
    end
  end

  initial begin
    int a0, f0, a1, f1, s;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state, in and just after reset
    check_eq("R1", "rd_valid in reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check_eq("R1", "rd_valid after reset", int'(rd_valid), 0);
    check_eq("R1", "ready bank0 after reset", int'(req_ready), 1);
    req_bank = 1'b1;
    #1;
    check_eq("R1", "ready bank1 after reset", int'(req_ready), 1);

    // R2 / R4: full burst from column 0 on an idle block
    send(0, 3, 0, 4, 2, a0, f0);
    idle_req();
    drain();

    // R4 wrap and R5 partial, single and zero lengths
    send(1, 5, 2, 2, 2, a0, f0);
    idle_req();
    drain();
    send(0, 7, 3, 1, 2, a0, f0);
    idle_req();
    drain();
    send(1, 0, 1, 0, 2, a0, f0);
    idle_req();
    drain();

    // R6 / R7: second bank accepted during first core access, gapless return
    send(0, 2, 1, 4, 6, a0, f0);
    send(1, 6, 0, 3, 7, a1, f1);
    check_eq("R6", "second bank accept edge", a1, a0 + 1);
    // R9: both banks busy, ready low for either target
    @(negedge clk);
    req_valid = 1'b0;
    req_bank  = 1'b0;
    #1;
    check_eq("R9", "ready bank0 while both busy", int'(req_ready), 0);
    req_bank = 1'b1;
    #1;
    check_eq("R9", "ready bank1 while both busy", int'(req_ready), 0);
    drain();

    // R8: same bank follow-up, accepted on the last beat, CORE_LAT dead cycles
    send(0, 4, 2, 3, 2, a0, f0);
    send(0, 1, 1, 4, 8, a1, f1);
    check_eq("R8", "follow-up accepted on last-beat edge", a1, f0 + N);
    check_eq("R8", "dead cycles between bursts", f1 - (f0 + N), LAT);
    idle_req();
    drain();

    // R7: mixed back-to-back stream across both banks
    s = 32'h1234;
    for (int i = 0; i < 12; i++) begin
      s = s * 1103515245 + 12345;
      send((s >> 16) & 1, (s >> 17) & 7, (s >> 20) & 3, (s >> 22) % 5, 7, a0, f0);
    end
    idle_req();
    drain();

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule